// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a host reach a bank of eight 12-bit control registers over a four-wire serial link. Each access is a single 16-bit frame. The host holds a select line high for the whole frame, sends one direction bit, then a 3-bit register number, then 12 data bits, all most significant bit first. A write frame updates the selected register once the select line drops. A read frame returns the selected register's value on the serial output while the 12 data bits are being clocked.

The serial clock, the select line and the serial input are brought into the system clock domain through synchronizer flops, and the block then works on detected edges. The serial clock may stop for any length of time inside a frame, so a host can split a frame into two byte transfers. Frames that do not carry exactly 16 bits are thrown away.

On the parallel side, the current value of every register is available, along with a one-cycle write strobe per register and the written data. A parameter mask selects registers whose read value comes from an external read-back input rather than from the stored copy.

Top module: `ser_regport`

## Requirements
- R1: While `rst` is high and after it is released, every register holds its reset value (register 0 to 7: 0xC10, 0x1FF, 0x030, 0x180, 0x510, 0x0A0, 0x3F0, 0x000). `sdo_out` is low and no write strobe is active.
- R2: A frame with first bit 0 (write) and exactly 16 serial clock rising edges loads the register numbered by bits 2..4 of the frame (MSB first) with bits 5..16 (MSB first). The update follows the falling edge of the select line. At that point exactly one write strobe, bit `n` for register `n`, pulses for one cycle with `wr_data` equal to the new value.
- R3: A write frame with fewer or more than 16 rising edges changes no register and raises no write strobe.
- R4: In a frame whose first bit is 1 (read), `sdo_out` presents the selected register's 12 bits MSB first. Bit 11 is valid at the rising edge of frame bit 5 and bit 0 at the rising edge of frame bit 16. The output changes only after serial clock falling edges.
- R5: A read frame changes no register and raises no strobe, whatever values sit on the 12 trailing input bits.
- R6: `sdo_out` is low while the select line is low, during the direction and address bits of any frame, and throughout write frames.
- R7: The serial clock may pause for any number of system cycles between bits with select high, without changing the frame's outcome.
- R8: A register whose bit is set in `RD_EXT_MASK` (default: register 7 only) reads back the matching 12-bit slice of `rd_ext`. Writes to it still update `cfg_q` and pulse its strobe.
- R9: Every rising edge of the select line restarts bit counting, so a frame that follows a broken one is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sel | input | 1 | Frame select from host, active high |
| sclk_in | input | 1 | Serial clock from host, idles low |
| sdi_in | input | 1 | Serial data from host |
| sdo_out | output | 1 | Serial read data to host |
| rd_ext | input | 96 | Per-register read-back values, register n at bits 12n+11..12n |
| wr_stb | output | 8 | One-cycle write strobe per register |
| wr_data | output | 12 | Value being written while a strobe is active |
| cfg_q | output | 96 | Current register values, register n at bits 12n+11..12n |

## Verification
A bit counter that slips by one position shifts both the address and the data. The next write then lands on the wrong register or with a rotated value, and a read-back shows it within one frame. A stale transmit-active flag or a wrongly loaded read shifter shows on `sdo_out` as non-zero bits in the header part of the frame, or as a wrong read word, in the same frame. A missed discard of a short or long frame shows at `cfg_q` and `wr_stb` a few system cycles after the select line falls.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int NREG = 8;
    localparam int AW   = $clog2(NREG);
    localparam int DW   = 12;
    localparam int FW   = 1 + AW + DW;
    localparam int HDR  = 1 + AW;

    localparam logic [NREG*DW-1:0] DEF_RESET = {
        12'h000, 12'h3F0, 12'h0A0, 12'h510,
        12'h180, 12'h030, 12'h1FF, 12'hC10
    };

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } frame_t;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [NREG-1:0] addr_dec(input logic [AW-1:0] a);
        return NREG'(1) << a;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_addr,
    output wr_req_t       wr_req,
    output logic          sdo
);

    localparam int CW = $clog2(FW + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(FW);
    localparam logic [CW-1:0] CNT_OVER = CW'(FW + 1);
    localparam logic [CW-1:0] CNT_HDR  = CW'(HDR);

    logic          cs_d, sck_d;
    logic          cs_rise, cs_fall, sck_rise, sck_fall;
    logic [CW-1:0] cnt;
    logic [FW-1:0] shreg;
    logic [DW-1:0] tx;
    logic          tx_act;
    frame_t        fr;
    hdr_t          hdr;

    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign sck_rise = cs_s & sck_s & ~sck_d;
    assign sck_fall = cs_s & ~sck_s & sck_d;

    assign fr      = frame_t'(shreg);
    assign hdr     = hdr_t'(shreg[HDR-1:0]);
    assign rd_addr = hdr.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    // receive side: bit counter and input shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_rise) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (sck_rise) begin
            if (cnt < CNT_FULL) begin
                shreg <= {shreg[FW-2:0], sdi_s};
                cnt   <= cnt + 1'b1;
            end else begin
                cnt   <= CNT_OVER;
            end
        end
    end

    // write request on frame close with exact length
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req <= '0;
        end else begin
            wr_req.vld  <= cs_fall && (cnt == CNT_FULL) && !fr.rd;
            wr_req.addr <= fr.addr;
            wr_req.data <= fr.data;
        end
    end

    // transmit side: load after the header, shift on falling edges
    always_ff @(posedge clk) begin
        if (rst) begin
            tx     <= '0;
            tx_act <= 1'b0;
        end else if (cs_rise || cs_fall) begin
            tx_act <= 1'b0;
            tx     <= '0;
        end else if (sck_fall) begin
            if (cnt == CNT_HDR && hdr.rd) begin
                tx     <= rd_word;
                tx_act <= 1'b1;
            end else if (tx_act && cnt > CNT_HDR && cnt < CNT_FULL) begin
                tx <= {tx[DW-2:0], 1'b0};
            end
        end
    end

    assign sdo = cs_s & tx_act & tx[DW-1];

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (cnt == '0));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sck_rise && !cs_rise && cnt < CNT_FULL) |=> (cnt == $past(cnt) + 1'b1));

    // R6
    tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_s) |=> !tx_act);

    // R2
    wr_after_close_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req.vld |-> !cs_s);

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter logic [NREG-1:0]    RD_EXT_MASK = 8'h80,
    parameter logic [NREG*DW-1:0] RST_VALS    = DEF_RESET
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr_req,
    input  logic [AW-1:0]      rd_addr,
    input  logic [NREG*DW-1:0] rd_ext,
    output logic [DW-1:0]      rd_word,
    output logic [NREG-1:0]    wr_stb,
    output logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] cfg_q
);

    logic [DW-1:0] regs   [NREG];
    logic [DW-1:0] rd_src [NREG];

    assign wr_stb  = wr_req.vld ? addr_dec(wr_req.addr) : '0;
    assign wr_data = wr_req.data;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= RST_VALS[g*DW +: DW];
                end else if (wr_stb[g]) begin
                    regs[g] <= wr_req.data;
                end
            end

            assign cfg_q[g*DW +: DW] = regs[g];

            if (RD_EXT_MASK[g]) begin : g_ext
                assign rd_src[g] = rd_ext[g*DW +: DW];
            end else begin : g_int
                logic unused_ext;
                assign unused_ext = ^rd_ext[g*DW +: DW];
                assign rd_src[g]  = regs[g];
            end
        end
    endgenerate

    assign rd_word = rd_src[rd_addr];

    // R2
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req.vld |=> (regs[$past(wr_req.addr)] == $past(wr_req.data)));

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_req.vld |=> $stable(cfg_q));

endmodule

// File: rtl/ser_regport.sv
module ser_regport
    import sreg_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [NREG-1:0]    RD_EXT_MASK = 8'h80,
    parameter logic [NREG*DW-1:0] RST_VALS    = DEF_RESET
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_sel,
    input  logic               sclk_in,
    input  logic               sdi_in,
    output logic               sdo_out,
    input  logic [NREG*DW-1:0] rd_ext,
    output logic [NREG-1:0]    wr_stb,
    output logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] cfg_q
);

    logic [2:0]    pins_s;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;
    wr_req_t       wr_req;

    sreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({frame_sel, sclk_in, sdi_in}),
        .q   (pins_s)
    );

    sreg_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (pins_s[2]),
        .sck_s   (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .wr_req  (wr_req),
        .sdo     (sdo_out)
    );

    sreg_bank #(.RD_EXT_MASK(RD_EXT_MASK), .RST_VALS(RST_VALS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_addr (rd_addr),
        .rd_ext  (rd_ext),
        .rd_word (rd_word),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .cfg_q   (cfg_q)
    );

    // R6
    sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_sel && !pins_s[2]) |-> !sdo_out);

endmodule

// File: tb/ser_regport_tb.sv
module ser_regport_tb;
    import sreg_pkg::*;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_sel = 1'b0, sclk_in = 1'b0, sdi_in = 1'b0;
    logic sdo_out;
    logic [NREG*DW-1:0] rd_ext;
    logic [NREG-1:0]    wr_stb;
    logic [DW-1:0]      wr_data;
    logic [NREG*DW-1:0] cfg_q;

    always #10 clk = ~clk;

    ser_regport u_dut (
        .clk(clk), .rst(rst), .frame_sel(frame_sel), .sclk_in(sclk_in),
        .sdi_in(sdi_in), .sdo_out(sdo_out), .rd_ext(rd_ext),
        .wr_stb(wr_stb), .wr_data(wr_data), .cfg_q(cfg_q)
    );

    typedef struct { string tag; logic [DW-1:0] v; } item_t;
    item_t exp_q[$];
    item_t obs_q[$];

    int checks = 0, failures = 0;
    int stb_count = 0, last_stb = -1;
    logic [DW-1:0] last_data = '0;
    logic [DW-1:0] model [NREG];
    logic done = 1'b0;
    logic [DW-1:0] ext7 = 12'h5E7;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // strobe monitor
    always @(negedge clk) begin
        if (!rst && wr_stb != '0) begin
            stb_count++;
            for (int i = 0; i < NREG; i++) if (wr_stb[i]) last_stb = i;
            last_data = wr_data;
            if ($countones(wr_stb) != 1) begin
                checks++; failures++;
                $display("FAIL R2 strobe not one-hot actual=%b expected=one bit", wr_stb);
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (obs_q.size() > 0 && exp_q.size() > 0) begin
            item_t o, e;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            chk(e.tag, o.v, e.v);
        end
    end

    task automatic frame(input logic [FW-1:0] word, input int nbits, input int pause_at,
                         output logic [DW-1:0] rx, output logic hdr_bad);
        rx = '0;
        hdr_bad = 1'b0;
        @(negedge clk) frame_sel = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi_in = (i < FW) ? word[FW-1-i] : 1'b1;
            repeat (H) @(negedge clk);
            if (i >= HDR && i < FW) rx[DW-1-(i-HDR)] = sdo_out;
            else if (sdo_out !== 1'b0) hdr_bad = 1'b1;
            sclk_in = 1'b1;
            repeat (H) @(negedge clk);
            sclk_in = 1'b0;
            if (i == pause_at) repeat (500) @(negedge clk);
        end
        repeat (H) @(negedge clk);
        frame_sel = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input int nbits, input int pause_at);
        logic [DW-1:0] rx;
        logic hb;
        frame({1'b0, AW'(a), d}, nbits, pause_at, rx, hb);
        if (nbits == FW) model[a] = d;
        chk("R6 sdo quiet in write", {11'b0, hb | (rx != '0)}, '0);
    endtask

    task automatic do_read(input string tag, input int a, input logic [DW-1:0] junk, input int pause_at);
        logic [DW-1:0] rx;
        logic hb;
        item_t e, o;
        e.tag = tag;
        e.v = (a == 7) ? ext7 : model[a];
        exp_q.push_back(e);
        frame({1'b1, AW'(a), junk}, FW, pause_at, rx, hb);
        o.tag = tag;
        o.v = rx;
        obs_q.push_back(o);
        chk("R6 sdo low in header", {11'b0, hb}, '0);
    endtask

    task automatic chk_bank(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, cfg_q[i*DW +: DW], model[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0;
        rd_ext = '0;
        rd_ext[7*DW +: DW] = ext7;
        model[0] = 12'hC10; model[1] = 12'h1FF; model[2] = 12'h030; model[3] = 12'h180;
        model[4] = 12'h510; model[5] = 12'h0A0; model[6] = 12'h3F0; model[7] = 12'h000;
        repeat (5) @(negedge clk);
        chk_bank("R1 during reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk_bank("R1 after reset");
        chk("R1 sdo low", {11'b0, sdo_out}, '0);
        chk("R1 no strobe", {4'b0, wr_stb}, '0);

        do_read("R1 R4 read reset reg0", 0, 12'h000, -1);
        do_read("R4 read reset reg4", 4, 12'hFFF, -1);

        s0 = stb_count;
        do_write(2, 12'hABC, FW, -1);
        chk("R2 one strobe", 12'(stb_count - s0), 12'd1);
        chk("R2 strobe index", 12'(last_stb), 12'd2);
        chk("R2 wr_data", last_data, 12'hABC);
        chk_bank("R2 bank after write");

        s0 = stb_count;
        do_read("R4 R5 read reg2 junk ones", 2, 12'hFFF, -1);
        do_read("R5 read reg2 junk pattern", 2, 12'h5A3, -1);
        chk("R5 read no strobe", 12'(stb_count - s0), 12'd0);
        chk_bank("R5 bank unchanged by read");

        s0 = stb_count;
        do_write(3, 12'h777, FW - 1, -1);
        do_write(4, 12'h111, FW + 1, -1);
        do_write(5, 12'h222, 6, -1);
        chk("R3 no strobe on bad length", 12'(stb_count - s0), 12'd0);
        chk_bank("R3 bank unchanged on bad length");

        do_write(1, 12'h3C5, FW, -1);
        chk_bank("R9 write after broken frames");

        do_write(5, 12'h5A5, FW, 7);
        chk_bank("R7 write with pause");
        do_read("R7 read with pause", 5, 12'h000, 9);

        for (int a = 0; a < NREG - 1; a++) begin
            do_write(a, 12'((a * 12'h29B) ^ 12'hF0F), FW, -1);
        end
        chk_bank("R2 all registers written");
        for (int a = 0; a < NREG - 1; a++) begin
            do_read("R4 readback sweep", a, 12'(a), -1);
        end

        s0 = stb_count;
        do_write(7, 12'h0F1, FW, -1);
        chk("R8 ext write strobe", 12'(last_stb), 12'd7);
        chk("R8 ext cfg_q updated", cfg_q[7*DW +: DW], 12'h0F1);
        do_read("R8 ext readback", 7, 12'h000, -1);
        rd_ext[7*DW +: DW] = 12'hA0A;
        ext7 = 12'hA0A;
        do_read("R8 ext readback changed", 7, 12'h000, -1);

        repeat (20) @(negedge clk);
        chk("R6 sdo low idle", {11'b0, sdo_out}, '0);
        chk("scoreboard drained", 12'(exp_q.size() + obs_q.size()), 12'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule